// File: doc/BRIEF.md
# Bit-Serial Clock-Chip Slave

This block is the slave side of a serial real-time clock and battery-RAM device that a host reaches by toggling three lines: a select, a serial clock and a data bit. Each transaction is sixteen serial-clock falling edges long. The first eight edges carry a command byte. The last eight carry a data byte. Depending on the command, the data phase either returns a byte to the host bit by bit, or takes in a byte that is stored once the sixteenth edge arrives.

Readable sources are a 32-byte RAM, a status byte, a control byte and six calendar fields. The calendar fields come in as binary inputs from counters outside the block and are returned as two-digit BCD. The data pin is split into an input, an output and an output enable, so that the pad logic can build the bidirectional line. The serial lines are sampled in the system clock domain and must be synchronous to it. The serial clock must stay at each level for at least two system clock cycles.

Top module: `rtc_serial_slave`

## Requirements
- R1: After reset the status byte is 0x90, the control byte is 0x00, `rtc_dout` and `rtc_dout_en` are 0, and RAM byte i holds (i*37 + INIT_SEED) mod 256, with INIT_SEED defaulting to 0x5A.
- R2: Only a falling edge of `rtc_sclk` seen while `rtc_sel` is high advances a transaction. Serial-clock edges while `rtc_sel` is low have no effect.
- R3: The first 8 falling edges shift the command in from `rtc_din`, MSB first. The next 8 shift in the data value, MSB first.
- R4: For commands 0x00–0x1F, each of falling edges 9 to 16 drives one bit of RAM byte [command] on `rtc_dout`, MSB first, with `rtc_dout_en` high. Each bit stays until the next edge.
- R5: Command 0x30 returns the status byte and command 0x31 returns the control byte, in the same bit order as R4.
- R6: Commands 0x20, 0x21, 0x22, 0x24, 0x25 and 0x26 return seconds, minutes, hours, day, month and year as two-digit BCD (high nibble tens). Every other command in 0x20–0x2F returns 0x00.
- R7: For commands 0x80–0x9F, the received value is written into RAM byte (command − 0x80) at the 16th falling edge. A transaction aborted before that edge writes nothing.
- R8: At the 16th edge, command 0xB1 stores the received value as the control byte. If value bit 2 is set, it also clears status bits 3 and 4 and raises `pwrfail_clr` for exactly one clock cycle; otherwise the status is unchanged and there is no pulse.
- R9: While `rtc_sel` is low, the phase, command and value are held at zero, and `rtc_dout` and `rtc_dout_en` are 0.
- R10: After the 16th edge, further falling edges change nothing until `rtc_sel` goes low and then high again.
- R11: Commands that are not reads (0x32–0x7F, 0x80 and above) never raise `rtc_dout_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rtc_sel | input | 1 | Transaction select; low aborts |
| rtc_sclk | input | 1 | Serial clock; falling edges sample |
| rtc_din | input | 1 | Serial data from the host |
| rtc_dout | output | 1 | Serial read data to the host |
| rtc_dout_en | output | 1 | Output enable for the data pad |
| tod_sec | input | 7 | Seconds, binary 0–59 |
| tod_min | input | 7 | Minutes, binary 0–59 |
| tod_hour | input | 7 | Hours, binary 0–23 |
| tod_day | input | 7 | Day of month, binary 1–31 |
| tod_month | input | 7 | Month, binary 1–12 |
| tod_year | input | 7 | Year within century, binary 0–99 |
| pwrfail_clr | output | 1 | One-cycle pulse to clear the power-fail interrupt |

## Verification
A wrong phase count or a wrong shift direction shows as a bit-reversed or rotated byte on `rtc_dout`. It appears within the same sixteen-edge transaction, so every read of a RAM byte with a known value exposes it. Commit faults behave differently. A write committed early, late or after an abort only shows in a later read-back, so every write is followed by a read of the same location. Status and control faults stay hidden until commands 0x30 and 0x31 are read, so those reads bracket every 0xB1 transaction, and the `pwrfail_clr` pulse is counted at the port.

// File: rtl/rtc_serial_pkg.sv
package rtc_serial_pkg;

    localparam int BYTE_W     = 8;
    localparam int PHASE_W    = 5;
    localparam int PH_CMD_END = 8;
    localparam int PH_DONE    = 16;

    localparam logic [7:0] CMD_STAT_RD  = 8'h30;
    localparam logic [7:0] CMD_CTRL_RD  = 8'h31;
    localparam logic [7:0] CMD_CTRL_WR  = 8'hB1;
    localparam logic [7:0] CMD_WR_BASE  = 8'h80;
    localparam logic [7:0] STATUS_RST   = 8'h90;
    localparam logic [7:0] CTRL_RST     = 8'h00;
    localparam logic [7:0] STAT_CLR_MSK = 8'h18;
    localparam int         CTRL_CLR_BIT = 2;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_RAM_RD,
        OP_TIME_RD,
        OP_STAT_RD,
        OP_CTRL_RD,
        OP_RAM_WR,
        OP_CTRL_WR
    } rtc_op_e;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [6:0] hour;
        logic [6:0] day;
        logic [6:0] month;
        logic [6:0] year;
    } tod_t;

    function automatic rtc_op_e op_decode(input logic [7:0] c, input int ram_bytes);
        if (int'(c) < ram_bytes)                                  return OP_RAM_RD;
        if (c[7:4] == 4'h2)                                       return OP_TIME_RD;
        if (c == CMD_STAT_RD)                                     return OP_STAT_RD;
        if (c == CMD_CTRL_RD)                                     return OP_CTRL_RD;
        if (c >= CMD_WR_BASE && int'(c - CMD_WR_BASE) < ram_bytes) return OP_RAM_WR;
        if (c == CMD_CTRL_WR)                                     return OP_CTRL_WR;
        return OP_NONE;
    endfunction

    function automatic logic op_is_read(input rtc_op_e op);
        return (op == OP_RAM_RD) || (op == OP_TIME_RD) ||
               (op == OP_STAT_RD) || (op == OP_CTRL_RD);
    endfunction

    function automatic logic [7:0] to_bcd(input logic [6:0] b);
        logic [6:0] tens;
        logic [6:0] ones;
        tens = b / 7'd10;
        ones = b % 7'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [7:0] time_field(input logic [3:0] sel, input tod_t t);
        case (sel)
            4'h0:    return to_bcd(t.sec);
            4'h1:    return to_bcd(t.min);
            4'h2:    return to_bcd(t.hour);
            4'h4:    return to_bcd(t.day);
            4'h5:    return to_bcd(t.month);
            4'h6:    return to_bcd(t.year);
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] ram_init(input int idx, input logic [7:0] seed);
        return 8'(idx * 37) + seed;
    endfunction

endpackage

// File: rtl/rtc_serial_edge.sv
module rtc_serial_edge (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic sclk,
    output logic fall
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk;
    end

    assign fall = sel & sclk_q & ~sclk;
endmodule

// File: rtl/rtc_serial_shift.sv
module rtc_serial_shift
    import rtc_serial_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sel,
    input  logic               fall,
    input  logic               din,
    output logic [PHASE_W-1:0] phase,
    output logic [7:0]         cmd,
    output logic [7:0]         val,
    output logic [7:0]         val_nxt,
    output logic               data_fall,
    output logic [2:0]         bit_idx,
    output logic               commit
);
    logic in_cmd;
    logic in_data;

    always_comb begin
        in_cmd    = phase < PHASE_W'(PH_CMD_END);
        in_data   = !in_cmd && (phase < PHASE_W'(PH_DONE));
        val_nxt   = {val[6:0], din};
        data_fall = fall && in_data;
        bit_idx   = phase[2:0];
        commit    = data_fall && (phase == PHASE_W'(PH_DONE - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || !sel) begin
            phase <= '0;
            cmd   <= '0;
            val   <= '0;
        end else if (fall && (in_cmd || in_data)) begin
            phase <= phase + 1'b1;
            if (in_cmd) cmd <= {cmd[6:0], din};
            else        val <= val_nxt;
        end
    end
endmodule

// File: rtl/rtc_serial_regs.sv
module rtc_serial_regs
    import rtc_serial_pkg::*;
#(
    parameter int         RAM_BYTES = 32,
    parameter logic [7:0] INIT_SEED = 8'h5A
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] cmd,
    input  logic [7:0] val_nxt,
    input  logic       commit,
    input  tod_t       tod,
    output logic [7:0] rd_byte,
    output logic       rd_ok,
    output logic [7:0] status,
    output logic       pwr_clr
);
    localparam int AW = $clog2(RAM_BYTES);

    logic [7:0] mem [RAM_BYTES];
    logic [7:0] ctrl;
    rtc_op_e    op;
    logic [AW-1:0] idx;

    always_comb begin
        op  = op_decode(cmd, RAM_BYTES);
        idx = cmd[AW-1:0];
        case (op)
            OP_RAM_RD:  rd_byte = mem[idx];
            OP_TIME_RD: rd_byte = time_field(cmd[3:0], tod);
            OP_STAT_RD: rd_byte = status;
            OP_CTRL_RD: rd_byte = ctrl;
            default:    rd_byte = 8'h00;
        endcase
        rd_ok = op_is_read(op);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RAM_BYTES; i++) mem[i] <= ram_init(i, INIT_SEED);
        end else if (commit && op == OP_RAM_WR) begin
            mem[idx] <= val_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status  <= STATUS_RST;
            ctrl    <= CTRL_RST;
            pwr_clr <= 1'b0;
        end else begin
            pwr_clr <= 1'b0;
            if (commit && op == OP_CTRL_WR) begin
                ctrl <= val_nxt;
                if (val_nxt[CTRL_CLR_BIT]) begin
                    status  <= status & ~STAT_CLR_MSK;
                    pwr_clr <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rtc_serial_drv.sv
module rtc_serial_drv (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel,
    input  logic       data_fall,
    input  logic [2:0] bit_idx,
    input  logic       rd_ok,
    input  logic [7:0] rd_byte,
    output logic       dout,
    output logic       dout_en
);
    always_ff @(posedge clk) begin
        if (rst || !sel) begin
            dout    <= 1'b0;
            dout_en <= 1'b0;
        end else if (data_fall && rd_ok) begin
            dout    <= rd_byte[3'd7 - bit_idx];
            dout_en <= 1'b1;
        end
    end
endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
    import rtc_serial_pkg::*;
#(
    parameter int         RAM_BYTES = 32,
    parameter logic [7:0] INIT_SEED = 8'h5A
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rtc_sel,
    input  logic       rtc_sclk,
    input  logic       rtc_din,
    output logic       rtc_dout,
    output logic       rtc_dout_en,
    input  logic [6:0] tod_sec,
    input  logic [6:0] tod_min,
    input  logic [6:0] tod_hour,
    input  logic [6:0] tod_day,
    input  logic [6:0] tod_month,
    input  logic [6:0] tod_year,
    output logic       pwrfail_clr
);
    logic               fall;
    logic [PHASE_W-1:0] phase;
    logic [7:0]         cmd_q;
    logic [7:0]         val_q;
    logic [7:0]         val_nxt;
    logic               data_fall;
    logic [2:0]         bit_idx;
    logic               commit;
    logic [7:0]         rd_byte;
    logic               rd_ok;
    logic [7:0]         status_q;
    tod_t               tod;

    assign tod = '{sec: tod_sec, min: tod_min, hour: tod_hour,
                   day: tod_day, month: tod_month, year: tod_year};

    rtc_serial_edge u_edge (
        .clk(clk), .rst(rst), .sel(rtc_sel), .sclk(rtc_sclk), .fall(fall)
    );

    rtc_serial_shift u_shift (
        .clk(clk), .rst(rst), .sel(rtc_sel), .fall(fall), .din(rtc_din),
        .phase(phase), .cmd(cmd_q), .val(val_q), .val_nxt(val_nxt),
        .data_fall(data_fall), .bit_idx(bit_idx), .commit(commit)
    );

    rtc_serial_regs #(.RAM_BYTES(RAM_BYTES), .INIT_SEED(INIT_SEED)) u_regs (
        .clk(clk), .rst(rst), .cmd(cmd_q), .val_nxt(val_nxt), .commit(commit),
        .tod(tod), .rd_byte(rd_byte), .rd_ok(rd_ok), .status(status_q),
        .pwr_clr(pwrfail_clr)
    );

    rtc_serial_drv u_drv (
        .clk(clk), .rst(rst), .sel(rtc_sel), .data_fall(data_fall),
        .bit_idx(bit_idx), .rd_ok(rd_ok), .rd_byte(rd_byte),
        .dout(rtc_dout), .dout_en(rtc_dout_en)
    );
endmodule

// File: rtl/rtc_serial_slave_chk.sv
module rtc_serial_slave_chk
    import rtc_serial_pkg::*;
#(
    parameter int RAM_BYTES = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               sel,
    input logic [PHASE_W-1:0] phase,
    input logic [7:0]         cmd,
    input logic [7:0]         val,
    input logic               commit,
    input logic               dout_en,
    input logic               pwr_clr,
    input logic [7:0]         status
);
    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !sel |=> (phase == '0 && cmd == 8'h00 && val == 8'h00 && !dout_en)); // R9

    AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (sel && phase == PHASE_W'(PH_DONE)) |=>
        (phase == PHASE_W'(PH_DONE) && $stable(cmd) && $stable(val))); // R10

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
        phase <= PHASE_W'(PH_DONE)); // R3

    AST_EN_IN_DATA: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> (phase > PHASE_W'(PH_CMD_END))); // R4

    AST_EN_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> op_is_read(op_decode(cmd, RAM_BYTES))); // R11

    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pwr_clr |=> !pwr_clr); // R8

    AST_CLR_FROM_COMMIT: assert property (@(posedge clk) disable iff (rst)
        pwr_clr |-> $past(commit && cmd == CMD_CTRL_WR)); // R8

    AST_STATUS_NO_SET: assert property (@(posedge clk) disable iff (rst)
        (status & ~$past(status)) == 8'h00); // R8
endmodule

bind rtc_serial_slave rtc_serial_slave_chk #(.RAM_BYTES(RAM_BYTES)) u_chk (
    .clk(clk), .rst(rst), .sel(rtc_sel), .phase(phase), .cmd(cmd_q),
    .val(val_q), .commit(commit), .dout_en(rtc_dout_en),
    .pwr_clr(pwrfail_clr), .status(status_q)
);

// File: tb/rtc_serial_slave_test.sv
module rtc_serial_slave_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel = 1'b0;
    logic       sclk = 1'b0;
    logic       din = 1'b0;
    logic       dout;
    logic       dout_en;
    logic [6:0] t_sec = 7'd59, t_min = 7'd7, t_hour = 7'd23;
    logic [6:0] t_day = 7'd31, t_month = 7'd12, t_year = 7'd99;
    logic       pclr;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rtc_serial_slave uut (
        .clk(clk), .rst(rst), .rtc_sel(sel), .rtc_sclk(sclk), .rtc_din(din),
        .rtc_dout(dout), .rtc_dout_en(dout_en),
        .tod_sec(t_sec), .tod_min(t_min), .tod_hour(t_hour),
        .tod_day(t_day), .tod_month(t_month), .tod_year(t_year),
        .pwrfail_clr(pclr)
    );

    always @(posedge clk) if (!rst && pclr) pulses <= pulses + 1;

    function automatic logic [7:0] ram_exp(input int i);
        return 8'(i * 37) + 8'h5A;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clk_bit(input logic b, output logic got, output logic en);
        @(negedge clk);
        din  = b;
        sclk = 1'b1;
        repeat (2) @(negedge clk);
        sclk = 1'b0;
        repeat (3) @(negedge clk);
        got = dout;
        en  = dout_en;
    endtask

    // Runs nbits edges with select high, leaves select high.
    task automatic xfer(input logic [7:0] c, input logic [7:0] v, input int nbits,
                        output logic [7:0] rd, output logic en_mid);
        logic b, got, en;
        rd = 8'h00;
        en_mid = 1'b0;
        @(negedge clk);
        sel = 1'b1;
        @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            b = (i < 8) ? c[7 - i] : v[15 - i];
            clk_bit(b, got, en);
            if (i >= 8) rd[15 - i] = got;
            if (i == 11) en_mid = en;
        end
    endtask

    task automatic drop_sel();
        @(negedge clk);
        sel = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic rd_byte(input logic [7:0] c, output logic [7:0] rd);
        logic en;
        xfer(c, 8'h00, 16, rd, en);
        drop_sel();
    endtask

    task automatic wr_byte(input logic [7:0] c, input logic [7:0] v);
        logic [7:0] rd;
        logic en;
        xfer(c, v, 16, rd, en);
        drop_sel();
    endtask

    task automatic t_reset();
        logic [7:0] r;
        chk("R1 dout after reset", dout, 0);
        chk("R1 dout_en after reset", dout_en, 0);
        chk("R1 no pulse at reset", pclr, 0);
        rd_byte(8'h30, r); chk("R1 status reset", r, 8'h90);
        rd_byte(8'h31, r); chk("R1 control reset", r, 8'h00);
        rd_byte(8'h00, r); chk("R1 R4 ram[0] init", r, ram_exp(0));
        rd_byte(8'h1F, r); chk("R1 R4 ram[31] init", r, ram_exp(31));
    endtask

    task automatic t_read_enable();
        logic [7:0] r;
        logic en;
        xfer(8'h07, 8'h00, 16, r, en);
        chk("R4 ram[7] bits msb first", r, ram_exp(7));
        chk("R4 dout_en during read", en, 1);
        drop_sel();
        chk("R9 dout_en low after deselect", dout_en, 0);
        chk("R9 dout low after deselect", dout, 0);
    endtask

    task automatic t_time();
        logic [7:0] r;
        rd_byte(8'h20, r); chk("R6 seconds bcd", r, 8'h59);
        rd_byte(8'h21, r); chk("R6 minutes bcd", r, 8'h07);
        rd_byte(8'h22, r); chk("R6 hours bcd", r, 8'h23);
        rd_byte(8'h24, r); chk("R6 day bcd", r, 8'h31);
        rd_byte(8'h25, r); chk("R6 month bcd", r, 8'h12);
        rd_byte(8'h26, r); chk("R6 year bcd", r, 8'h99);
        rd_byte(8'h23, r); chk("R6 unused 0x23 zero", r, 8'h00);
        rd_byte(8'h2F, r); chk("R6 unused 0x2F zero", r, 8'h00);
        t_sec = 7'd0;
        rd_byte(8'h20, r); chk("R6 seconds zero", r, 8'h00);
    endtask

    task automatic t_write();
        logic [7:0] r;
        logic en;
        wr_byte(8'h85, 8'hC3);
        rd_byte(8'h05, r); chk("R7 R3 write 0x85 readback", r, 8'hC3);
        wr_byte(8'h9F, 8'h11);
        rd_byte(8'h1F, r); chk("R7 write top byte readback", r, 8'h11);
        xfer(8'h82, 8'h3C, 15, r, en);
        drop_sel();
        rd_byte(8'h02, r); chk("R7 aborted write leaves ram", r, ram_exp(2));
        xfer(8'h86, 8'h55, 16, r, en);
        chk("R11 write cmd no dout_en", en, 0);
        drop_sel();
        xfer(8'h40, 8'h00, 16, r, en);
        chk("R11 cmd 0x40 no dout_en", en, 0);
        chk("R11 cmd 0x40 dout low", r, 8'h00);
        drop_sel();
    endtask

    task automatic t_ctrl();
        logic [7:0] r;
        int p0;
        p0 = pulses;
        wr_byte(8'hB1, 8'h02);
        chk("R8 no pulse without bit2", pulses - p0, 0);
        rd_byte(8'h30, r); chk("R8 status kept without bit2", r, 8'h90);
        rd_byte(8'h31, r); chk("R5 R8 control written", r, 8'h02);
        wr_byte(8'hB1, 8'h04);
        chk("R8 one pulse with bit2", pulses - p0, 1);
        rd_byte(8'h30, r); chk("R5 R8 status bits 3,4 cleared", r, 8'h80);
        rd_byte(8'h31, r); chk("R5 control readback", r, 8'h04);
    endtask

    task automatic t_extra_edges();
        logic [7:0] r;
        logic en, got;
        xfer(8'h83, 8'h0F, 16, r, en);
        for (int i = 0; i < 6; i++) clk_bit(1'b1, got, en);
        drop_sel();
        rd_byte(8'h03, r); chk("R10 extra edges no change to write", r, 8'h0F);
        xfer(8'h00, 8'h00, 16, r, en);
        for (int i = 0; i < 4; i++) clk_bit(1'b1, got, en);
        chk("R10 dout holds last bit", got, ram_exp(0) & 8'h01);
        chk("R10 dout_en holds", en, 1);
        drop_sel();
    endtask

    task automatic t_sel_low();
        logic [7:0] r;
        logic got, en;
        for (int i = 0; i < 10; i++) clk_bit(1'b1, got, en);
        chk("R2 edges with sel low: no drive", en, 0);
        rd_byte(8'h1F, r); chk("R2 R3 clean transaction after idle edges", r, 8'h11);
        rd_byte(8'h30, r); chk("R2 status after idle edges", r, 8'h80);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_read_enable();
        t_time();
        t_write();
        t_ctrl();
        t_extra_edges();
        t_sel_low();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule